// File: doc/BRIEF.md
# Host Aperture Window Remapper

This block sits behind a 1 MB host-visible register aperture and turns each 32-bit access into an access on a 32 MB internal address space. The lower half of the aperture maps one-to-one onto the bottom of the internal space. Accesses in the upper half are relocated: the low 19 offset bits are kept, and the six internal address bits above them come from a window field held in a control register inside the block. The control register itself is reached through the direct half of the aperture and is served locally, never forwarded.

The requester side is a valid/ready request channel and a one-cycle response pulse. A request is taken on a clock edge where `s_req_valid` and `s_req_ready` are both high. Until then the requester must keep `s_req_valid` and every request field steady. `s_req_ready` stays low while an access is in flight, so there is never more than one access outstanding. The internal side raises `m_valid` and keeps address, direction and write data steady until the memory returns `m_ack`. Read data is taken from `m_rdata` on the same edge. Accesses to the relocated half while the window is disabled are not forwarded. Reads of that kind return a poison word, and a sticky error flag is set.

Top module: `bar_window_remap`

## Requirements
- R1: An accepted access whose offset has bit 19 clear, other than the control word, is forwarded with `m_addr` equal to the offset zero-extended to 25 bits, with the same direction and write data.
- R2: An accepted access whose offset has bit 19 set, while the window is enabled, is forwarded with `m_addr[24:19]` equal to the stored window field and `m_addr[18:0]` equal to offset bits 18:0.
- R3: The control word sits at offset 0x310C, and offset bits 1:0 are ignored when matching it. An access to it is never forwarded. A write stores data bit 31 as the window enable and data bits 5:0 as the window field. A read returns the enable in bit 31 and the window field in bits 5:0.
- R4: Control word bits 30:6 always read as zero, whatever value was written.
- R5: An access with offset bit 19 set while the enable is clear raises no `m_valid`. A read of this kind returns 0xDEADBEEF and a write is dropped. `err_flag` rises and stays high until reset.
- R6: A control write changes the mapping used for the very next accepted access.
- R7: After reset the control word reads 0x00000000, `err_flag` is 0, `m_valid` is 0 and `s_req_ready` is 1.
- R8: Every accepted request gives exactly one single-cycle `s_rsp_valid` pulse. For a forwarded access it comes in the cycle after the `m_ack` edge. For a local access it comes in the cycle after acceptance. `s_req_ready` is low from acceptance until that pulse ends. Read data is on `s_rsp_rdata` during the pulse, and writes return 0.
- R9: While `m_valid` is high and `m_ack` is low, `m_valid`, `m_addr`, `m_write` and `m_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_req_valid | input | 1 | Aperture request present |
| s_req_ready | output | 1 | Block can take a request |
| s_req_write | input | 1 | 1 = write, 0 = read |
| s_req_addr | input | 20 | Aperture byte offset |
| s_req_wdata | input | 32 | Write data |
| s_rsp_valid | output | 1 | One-cycle completion pulse |
| s_rsp_rdata | output | 32 | Read data, valid with s_rsp_valid |
| m_valid | output | 1 | Internal access request |
| m_ack | input | 1 | Internal access done |
| m_write | output | 1 | Internal access direction |
| m_addr | output | 25 | Internal byte address |
| m_wdata | output | 32 | Internal write data |
| m_rdata | input | 32 | Internal read data, taken with m_ack |
| err_flag | output | 1 | Sticky flag for blocked window accesses |

## Verification
The mapping is tried with offsets at both ends of the direct half, next to the control word, and at both ends of the relocated half under window values 0, 0x15 and 0x3F. This separates a correct field splice from an off-by-one split, from a window that is ignored, and from the aliasing of window 0 onto the direct half. Control traffic uses all four byte aliases of the control word and an all-ones write, which shows whether decode ignores bits 1:0 and whether the reserved bits stay clear. Window changes placed right before a relocated access, and disabling the window after use, show when a new setting starts to apply and confirm the blocked path. Memory latencies of 0, 1 and 3 cycles test the request hold and the timing of the completion pulse.

// File: rtl/bwr_pkg.sv
package bwr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FWD  = 2'd1,
    ST_RSP  = 2'd2
  } bwr_state_e;

  typedef enum logic [1:0] {
    TGT_DIRECT  = 2'd0,
    TGT_WINDOW  = 2'd1,
    TGT_CTRL    = 2'd2,
    TGT_BLOCKED = 2'd3
  } bwr_target_e;

endpackage

// File: rtl/bwr_decode.sv
module bwr_decode
  import bwr_pkg::*;
#(
  parameter int SLV_AW = 20,
  parameter int INT_AW = 25,
  parameter logic [SLV_AW-1:0] CTRL_OFS = 20'h0310C,
  localparam int SPLIT = SLV_AW - 1,
  localparam int WIN_W = INT_AW - SPLIT
) (
  input  logic [SLV_AW-1:0] addr,
  input  logic              win_en,
  input  logic [WIN_W-1:0]  win_sel,
  output bwr_target_e       target,
  output logic [INT_AW-1:0] int_addr
);

  logic              ctrl_hit;
  logic              upper_half;
  logic [INT_AW-1:0] direct_addr;
  logic [INT_AW-1:0] window_addr;

  assign ctrl_hit   = (addr[SLV_AW-1:2] == CTRL_OFS[SLV_AW-1:2]);
  assign upper_half = addr[SPLIT];

  generate
    if (INT_AW > SLV_AW) begin : g_ext
      assign direct_addr = {{(INT_AW-SLV_AW){1'b0}}, addr};
    end else begin : g_same
      assign direct_addr = addr[INT_AW-1:0];
    end
  endgenerate

  assign window_addr = {win_sel, addr[SPLIT-1:0]};

  always_comb begin
    target   = TGT_DIRECT;
    int_addr = direct_addr;
    if (upper_half) begin
      if (win_en) begin
        target   = TGT_WINDOW;
        int_addr = window_addr;
      end else begin
        target   = TGT_BLOCKED;
      end
    end else if (ctrl_hit) begin
      target = TGT_CTRL;
    end
  end

endmodule

// File: rtl/bwr_ctrl_reg.sv
module bwr_ctrl_reg #(
  parameter int DW     = 32,
  parameter int WIN_W  = 6,
  parameter int EN_BIT = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DW-1:0]    wdata,
  output logic             win_en,
  output logic [WIN_W-1:0] win_sel,
  output logic [DW-1:0]    rdata
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_en  <= 1'b0;
      win_sel <= '0;
    end else if (wr_en) begin
      win_en  <= wdata[EN_BIT];
      win_sel <= wdata[WIN_W-1:0];
    end
  end

  always_comb begin
    rdata              = '0;
    rdata[EN_BIT]      = win_en;
    rdata[WIN_W-1:0]   = win_sel;
  end

endmodule

// File: rtl/bwr_seq.sv
module bwr_seq
  import bwr_pkg::*;
#(
  parameter int DW     = 32,
  parameter int INT_AW = 25,
  parameter logic [DW-1:0] POISON = 32'hDEADBEEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_req_valid,
  input  logic              s_req_write,
  input  logic [DW-1:0]     s_req_wdata,
  output logic              s_req_ready,
  input  bwr_target_e       target,
  input  logic [INT_AW-1:0] int_addr,
  input  logic [DW-1:0]     ctrl_rdata,
  output logic              ctrl_wr,
  output logic              m_valid,
  output logic              m_write,
  output logic [INT_AW-1:0] m_addr,
  output logic [DW-1:0]     m_wdata,
  input  logic              m_ack,
  input  logic [DW-1:0]     m_rdata,
  output logic              s_rsp_valid,
  output logic [DW-1:0]     s_rsp_rdata,
  output logic              err_flag
);

  bwr_state_e state;
  logic       accept;

  assign accept      = s_req_valid && (state == ST_IDLE);
  assign ctrl_wr     = accept && s_req_write && (target == TGT_CTRL);
  assign s_req_ready = (state == ST_IDLE);
  assign m_valid     = (state == ST_FWD);
  assign s_rsp_valid = (state == ST_RSP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      m_write     <= 1'b0;
      m_addr      <= '0;
      m_wdata     <= '0;
      s_rsp_rdata <= '0;
      err_flag    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            unique case (target)
              TGT_DIRECT, TGT_WINDOW: begin
                state   <= ST_FWD;
                m_write <= s_req_write;
                m_addr  <= int_addr;
                m_wdata <= s_req_wdata;
              end
              TGT_CTRL: begin
                state       <= ST_RSP;
                s_rsp_rdata <= s_req_write ? '0 : ctrl_rdata;
              end
              TGT_BLOCKED: begin
                state       <= ST_RSP;
                s_rsp_rdata <= s_req_write ? '0 : POISON;
                err_flag    <= 1'b1;
              end
            endcase
          end
        end
        ST_FWD: begin
          if (m_ack) begin
            state       <= ST_RSP;
            s_rsp_rdata <= m_write ? '0 : m_rdata;
          end
        end
        default: begin
          state <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/bar_window_remap.sv
module bar_window_remap
  import bwr_pkg::*;
#(
  parameter int SLV_AW = 20,
  parameter int INT_AW = 25,
  parameter int DW     = 32,
  parameter int EN_BIT = 31,
  parameter logic [SLV_AW-1:0] CTRL_OFS = 20'h0310C,
  parameter logic [DW-1:0]     POISON   = 32'hDEADBEEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_req_valid,
  output logic              s_req_ready,
  input  logic              s_req_write,
  input  logic [SLV_AW-1:0] s_req_addr,
  input  logic [DW-1:0]     s_req_wdata,
  output logic              s_rsp_valid,
  output logic [DW-1:0]     s_rsp_rdata,
  output logic              m_valid,
  input  logic              m_ack,
  output logic              m_write,
  output logic [INT_AW-1:0] m_addr,
  output logic [DW-1:0]     m_wdata,
  input  logic [DW-1:0]     m_rdata,
  output logic              err_flag
);

  localparam int SPLIT = SLV_AW - 1;
  localparam int WIN_W = INT_AW - SPLIT;

  logic              win_en;
  logic [WIN_W-1:0]  win_sel;
  logic [DW-1:0]     ctrl_rdata;
  logic              ctrl_wr;
  bwr_target_e       target;
  logic [INT_AW-1:0] int_addr;

  bwr_decode #(
    .SLV_AW  (SLV_AW),
    .INT_AW  (INT_AW),
    .CTRL_OFS(CTRL_OFS)
  ) u_decode (
    .addr    (s_req_addr),
    .win_en  (win_en),
    .win_sel (win_sel),
    .target  (target),
    .int_addr(int_addr)
  );

  bwr_ctrl_reg #(
    .DW    (DW),
    .WIN_W (WIN_W),
    .EN_BIT(EN_BIT)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ctrl_wr),
    .wdata  (s_req_wdata),
    .win_en (win_en),
    .win_sel(win_sel),
    .rdata  (ctrl_rdata)
  );

  bwr_seq #(
    .DW    (DW),
    .INT_AW(INT_AW),
    .POISON(POISON)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_req_valid(s_req_valid),
    .s_req_write(s_req_write),
    .s_req_wdata(s_req_wdata),
    .s_req_ready(s_req_ready),
    .target     (target),
    .int_addr   (int_addr),
    .ctrl_rdata (ctrl_rdata),
    .ctrl_wr    (ctrl_wr),
    .m_valid    (m_valid),
    .m_write    (m_write),
    .m_addr     (m_addr),
    .m_wdata    (m_wdata),
    .m_ack      (m_ack),
    .m_rdata    (m_rdata),
    .s_rsp_valid(s_rsp_valid),
    .s_rsp_rdata(s_rsp_rdata),
    .err_flag   (err_flag)
  );

endmodule

// File: rtl/bwr_checker.sv
module bwr_checker #(
  parameter int SLV_AW = 20,
  parameter int INT_AW = 25,
  parameter int DW     = 32,
  parameter logic [SLV_AW-1:0] CTRL_OFS = 20'h0310C,
  localparam int SPLIT = SLV_AW - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_req_valid,
  input logic              s_req_ready,
  input logic [SLV_AW-1:0] s_req_addr,
  input logic              s_rsp_valid,
  input logic              m_valid,
  input logic              m_ack,
  input logic              m_write,
  input logic [INT_AW-1:0] m_addr,
  input logic [DW-1:0]     m_wdata,
  input logic              err_flag,
  input logic              win_en
);

  logic took;
  logic is_ctrl;
  assign took    = s_req_valid && s_req_ready;
  assign is_ctrl = (s_req_addr[SLV_AW-1:2] == CTRL_OFS[SLV_AW-1:2]);

  AST_LOWER_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (took && !s_req_addr[SPLIT] && !is_ctrl) |=>
      (m_valid && (m_addr[SLV_AW-1:0] == $past(s_req_addr)) && ((m_addr >> SLV_AW) == '0))); // R1

  AST_UPPER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (took && s_req_addr[SPLIT] && win_en) |=>
      (m_valid && (m_addr[SPLIT-1:0] == $past(s_req_addr[SPLIT-1:0])))); // R2

  AST_CTRL_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (took && !s_req_addr[SPLIT] && is_ctrl) |=> (s_rsp_valid && !m_valid)); // R3

  AST_BLOCKED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (took && s_req_addr[SPLIT] && !win_en) |=> (!m_valid && s_rsp_valid && err_flag)); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R5

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    s_rsp_valid |=> (!s_rsp_valid && s_req_ready)); // R8

  AST_ACK_TO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ack) |=> s_rsp_valid); // R8

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid || s_rsp_valid) |-> !s_req_ready); // R8

  AST_MREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ack) |=>
      (m_valid && $stable(m_addr) && $stable(m_write) && $stable(m_wdata))); // R9

endmodule

bind bar_window_remap bwr_checker #(
  .SLV_AW  (SLV_AW),
  .INT_AW  (INT_AW),
  .DW      (DW),
  .CTRL_OFS(CTRL_OFS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .s_req_valid(s_req_valid),
  .s_req_ready(s_req_ready),
  .s_req_addr (s_req_addr),
  .s_rsp_valid(s_rsp_valid),
  .m_valid    (m_valid),
  .m_ack      (m_ack),
  .m_write    (m_write),
  .m_addr     (m_addr),
  .m_wdata    (m_wdata),
  .err_flag   (err_flag),
  .win_en     (win_en)
);

// File: tb/sim_bar_window_remap.sv
`timescale 1ns/1ps
module sim_bar_window_remap;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_req_valid = 1'b0;
  logic        s_req_ready;
  logic        s_req_write = 1'b0;
  logic [19:0] s_req_addr = '0;
  logic [31:0] s_req_wdata = '0;
  logic        s_rsp_valid;
  logic [31:0] s_rsp_rdata;
  logic        m_valid;
  logic        m_ack = 1'b0;
  logic        m_write;
  logic [24:0] m_addr;
  logic [31:0] m_wdata;
  logic [31:0] m_rdata = '0;
  logic        err_flag;

  always #2.5 clk = ~clk;

  bar_window_remap u0 (
    .clk(clk), .rst_n(rst_n),
    .s_req_valid(s_req_valid), .s_req_ready(s_req_ready),
    .s_req_write(s_req_write), .s_req_addr(s_req_addr), .s_req_wdata(s_req_wdata),
    .s_rsp_valid(s_rsp_valid), .s_rsp_rdata(s_rsp_rdata),
    .m_valid(m_valid), .m_ack(m_ack), .m_write(m_write),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata),
    .err_flag(err_flag)
  );

  typedef struct packed {
    logic        w;
    logic [24:0] a;
    logic [31:0] d;
  } mreq_t;

  mreq_t       mreq_q[$];
  logic [31:0] rsp_q[$];
  string       rsp_tag_q[$];
  string       mreq_tag_q[$];

  logic [31:0] ref_mem [logic [24:0]];
  logic [31:0] act_mem [logic [24:0]];

  int  checks = 0;
  int  fails  = 0;
  int  lat    = 0;
  bit  done   = 0;

  bit        mdl_en  = 0;
  logic [5:0] mdl_win = '0;
  bit        mdl_err = 0;

  function automatic logic [31:0] fill(logic [24:0] a);
    return ({7'd0, a} * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // driver: model the expected outcome, queue it, then present the request
  task automatic access(bit w, logic [19:0] a, logic [31:0] d, string tag);
    logic [31:0] exp_r;
    logic [24:0] ia;
    mreq_t       mr;
    exp_r = '0;
    if (a[19:2] == 18'h00C43) begin
      if (w) begin
        mdl_en  = d[31];
        mdl_win = d[5:0];
      end else begin
        exp_r = {mdl_en, 25'd0, mdl_win};
      end
    end else if (!a[19] || mdl_en) begin
      ia = a[19] ? {mdl_win, a[18:0]} : {5'd0, a};
      mr.w = w; mr.a = ia; mr.d = w ? d : 32'd0;
      mreq_q.push_back(mr);
      mreq_tag_q.push_back(tag);
      if (w) ref_mem[ia] = d;
      else   exp_r = ref_mem.exists(ia) ? ref_mem[ia] : fill(ia);
    end else begin
      mdl_err = 1;
      exp_r = w ? 32'd0 : 32'hDEADBEEF;
    end
    rsp_q.push_back(exp_r);
    rsp_tag_q.push_back(tag);
    @(negedge clk);
    s_req_valid = 1'b1;
    s_req_write = w;
    s_req_addr  = a;
    s_req_wdata = d;
    while (!s_req_ready) @(negedge clk);
    @(negedge clk);
    s_req_valid = 1'b0;
    s_req_wdata = 32'hX5X5_0000 | 32'h0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((rsp_q.size() != 0 || !s_req_ready) && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    chk(rsp_q.size() == 0, "R8 drain", rsp_q.size(), 0);
  endtask

  // memory model on the internal side; also the master-side monitor
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (m_ack) begin
        m_ack = 1'b0;
        cnt = 0;
      end else if (rst_n && m_valid) begin
        if (cnt >= lat) begin
          if (mreq_q.size() == 0) begin
            chk(0, "R5 unexpected forward", {7'd0, m_addr}, 0);
          end else begin
            mreq_t e;
            string t;
            e = mreq_q.pop_front();
            t = mreq_tag_q.pop_front();
            chk(m_addr == e.a, {t, " m_addr"}, {7'd0, m_addr}, {7'd0, e.a});
            chk(m_write == e.w, {t, " m_write"}, {31'd0, m_write}, {31'd0, e.w});
            if (e.w) chk(m_wdata == e.d, {t, " m_wdata"}, m_wdata, e.d);
          end
          if (m_write) begin
            act_mem[m_addr] = m_wdata;
            m_rdata = 32'hCAFE_0000;
          end else begin
            m_rdata = act_mem.exists(m_addr) ? act_mem[m_addr] : fill(m_addr);
          end
          m_ack = 1'b1;
        end else begin
          cnt++;
        end
      end
    end
  end

  // response monitor: scoreboard pop and compare
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && s_rsp_valid) begin
        if (rsp_q.size() == 0) begin
          chk(0, "R8 unexpected response", s_rsp_rdata, 0);
        end else begin
          logic [31:0] e;
          string t;
          e = rsp_q.pop_front();
          t = rsp_tag_q.pop_front();
          chk(s_rsp_rdata == e, {t, " rdata"}, s_rsp_rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      summary();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    chk(err_flag == 1'b0, "R7 err_flag", {31'd0, err_flag}, 0);
    chk(m_valid == 1'b0, "R7 m_valid", {31'd0, m_valid}, 0);
    chk(s_req_ready == 1'b1, "R7 s_req_ready", {31'd0, s_req_ready}, 1);
    access(0, 20'h0310C, 0, "R7 ctrl after reset");
    drain();

    // R1 direct half at several latencies
    lat = 0;
    access(1, 20'h00000, 32'h1111_2222, "R1 wr low edge");
    access(0, 20'h00000, 0, "R1 rd low edge");
    lat = 1;
    access(1, 20'h7FFFC, 32'hA5A5_5A5A, "R1 wr top of direct");
    access(0, 20'h7FFFC, 0, "R1 rd top of direct");
    lat = 3;
    access(0, 20'h03108, 0, "R1 rd next to ctrl");
    access(0, 20'h03110, 0, "R1 rd after ctrl");
    drain();

    // R5 disabled window after reset
    lat = 0;
    access(0, 20'h80000, 0, "R5 blocked read");
    access(1, 20'hFFFFC, 32'h0BAD_F00D, "R5 blocked write");
    drain();
    chk(err_flag == 1'b1, "R5 err set", {31'd0, err_flag}, 1);

    // R3 / R4 control word and aliases
    access(1, 20'h0310C, 32'hFFFF_FFFF, "R4 ctrl all ones");
    access(0, 20'h0310C, 0, "R4 ctrl readback");
    access(1, 20'h0310D, 32'h8000_0015, "R3 ctrl alias wr");
    access(0, 20'h0310F, 0, "R3 ctrl alias rd");
    drain();

    // R2 window 0x15, then R6 immediate change
    lat = 1;
    access(1, 20'h80004, 32'h1357_9BDF, "R2 wr win15 bottom");
    access(0, 20'h80004, 0, "R2 rd win15 bottom");
    access(1, 20'h0310C, 32'h8000_003F, "R6 set win3f");
    access(0, 20'hFFFFC, 0, "R6 rd win3f top");
    access(1, 20'hFFFFC, 32'h2468_ACE0, "R2 wr win3f top");
    access(0, 20'hFFFFC, 0, "R2 rd win3f top");
    access(1, 20'h0310C, 32'h8000_0000, "R6 set win0");
    access(0, 20'h80000, 0, "R2 win0 aliases direct");
    lat = 3;
    access(1, 20'h0310C, 32'h8000_0015, "R6 back to win15");
    access(0, 20'h80004, 0, "R6 rd win15 again");
    drain();
    chk(err_flag == 1'b1, "R5 err sticky", {31'd0, err_flag}, 1);

    // R5 disable again: dropped write must not reach memory
    lat = 0;
    access(1, 20'h0310C, 32'h0000_0015, "R5 disable win");
    access(0, 20'h0310C, 0, "R3 ctrl disabled readback");
    access(1, 20'h80004, 32'hFFFF_0000, "R5 dropped write");
    access(0, 20'h80004, 0, "R5 blocked read again");
    access(1, 20'h0310C, 32'h8000_0015, "R6 re-enable");
    access(0, 20'h80004, 0, "R5 data untouched by dropped write");
    drain();

    repeat (5) @(negedge clk);
    chk(mreq_q.size() == 0, "R1 master queue empty", mreq_q.size(), 0);
    done = 1;
    summary();
  end

endmodule